// File: doc/BRIEF.md
# Priority Mailbox Transmit Arbiter

This block decides which of a bank of message mailboxes is handed next to a CAN-style bit engine for transmission. Every mailbox has an enable bit, a direction bit (0 means transmit), a pending-request flag and a 6-bit priority value. Software drives the flag vectors through a small write port. It can set requests, cancel them, and clear completion and cancellation acknowledges. Priorities are loaded through a separate indexed write port.

Among the mailboxes that are enabled, set to transmit and pending, the one with the largest priority value wins. When two candidates have the same priority, the higher mailbox number wins. The bit engine raises a start strobe when a frame slot is free. The arbiter then latches the current winner and holds it until the engine reports either that the frame completed or that the attempt was given up. Completion moves the request into the acknowledge vector. A summary interrupt is raised when any acknowledge bit is set and its mask bit is set.

Top module: `mbx_tx_arbiter`

## Requirements
- R1: After reset, every flag vector (enable, direction, pending, transmit acknowledge, cancel acknowledge, interrupt mask) is zero, and `win_valid`, `busy` and `mbx_irq` are low.
- R2: A write with `wr_sel` 0 loads the enable vector, `wr_sel` 1 loads the direction vector (1 = receive) and `wr_sel` 6 loads the interrupt mask. Each value is visible on its output after the clock edge that takes the write.
- R3: A write with `wr_sel` 2 sets the pending flag of each mailbox whose data bit is 1 and whose enable bit is 1. Data bits of 0, and mailboxes that are disabled, are left unchanged.
- R4: Clearing the enable bit of a mailbox also clears its pending flag.
- R5: The candidates are the mailboxes that are enabled, set to transmit and pending. While the block is not busy, `win_idx` names the candidate with the largest priority value, and ties go to the highest index. `win_valid` is low when there is no candidate.
- R6: A pulse on `prio_wr` stores `prio_val` (0 to 63) as the priority of mailbox `prio_idx`. Later arbitration uses the new value.
- R7: A `tx_start` pulse while `win_valid` is high and `busy` is low latches the winner and raises `busy`. While `busy` is high, `win_idx` stays fixed, even if a higher-priority request arrives.
- R8: `tx_done` while busy clears the latched mailbox's pending flag, sets its transmit-acknowledge bit and drops `busy`. `tx_abort` while busy drops `busy` and leaves the pending flag set.
- R9: A write with `wr_sel` 3 cancels each pending request whose data bit is 1 and sets the matching cancel-acknowledge bit. It has no effect on mailboxes that are not pending, and none on the mailbox currently latched.
- R10: Writes with `wr_sel` 4 and `wr_sel` 5 clear the transmit-acknowledge and cancel-acknowledge bits where the data bit is 1.
- R11: `mbx_irq` is high exactly when some bit that is set in either acknowledge vector also has its mask bit set.
- R12: `tx_start` with no candidate, and `tx_done` or `tx_abort` while not busy, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data, one bit per mailbox |
| prio_wr | input | 1 | Priority write strobe |
| prio_idx | input | 5 | Mailbox whose priority is written |
| prio_val | input | 6 | New priority value |
| tx_start | input | 1 | Engine has a free frame slot |
| tx_done | input | 1 | Engine finished the latched frame |
| tx_abort | input | 1 | Engine gave up the latched frame |
| win_valid | output | 1 | A winner is presented |
| win_idx | output | 5 | Index of the winning or latched mailbox |
| busy | output | 1 | A mailbox is latched in the slot |
| mbx_irq | output | 1 | Masked summary of both acknowledge vectors |
| mbx_en | output | 32 | Enable vector |
| mbx_dir | output | 32 | Direction vector |
| mbx_pend | output | 32 | Pending request vector |
| mbx_ack | output | 32 | Transmit-acknowledge vector |
| mbx_abt | output | 32 | Cancel-acknowledge vector |
| mbx_imask | output | 32 | Interrupt mask vector |

## Verification
The properties assume that the engine sends `tx_done` and `tx_abort` only as single-cycle pulses. They also assume that these strobes do not share a cycle with a register write that clears the same acknowledge bit. The stimulus drives every strobe for exactly one cycle. It keeps each engine strobe apart from any register write. It loads priorities only while nothing is latched.

// File: rtl/mbx_arb_pkg.sv
`timescale 1ns/1ps
package mbx_arb_pkg;
  typedef enum logic [2:0] {
    SEL_ENABLE  = 3'd0,
    SEL_DIR     = 3'd1,
    SEL_REQ_SET = 3'd2,
    SEL_REQ_CLR = 3'd3,
    SEL_ACK_CLR = 3'd4,
    SEL_ABT_CLR = 3'd5,
    SEL_IMASK   = 3'd6
  } wr_sel_e;
endpackage

// File: rtl/mbx_flag_bank.sv
`timescale 1ns/1ps
module mbx_flag_bank
  import mbx_arb_pkg::*;
#(
  parameter int NUM_MBX = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [NUM_MBX-1:0] wr_data,
  input  logic               slot_busy,
  input  logic [IDX_W-1:0]   slot_idx,
  input  logic               slot_done,
  output logic [NUM_MBX-1:0] en_q,
  output logic [NUM_MBX-1:0] dir_q,
  output logic [NUM_MBX-1:0] pend_q,
  output logic [NUM_MBX-1:0] ack_q,
  output logic [NUM_MBX-1:0] abt_q,
  output logic [NUM_MBX-1:0] imask_q
);
  localparam logic [NUM_MBX-1:0] ONE = {{(NUM_MBX-1){1'b0}}, 1'b1};

  logic [NUM_MBX-1:0] en_n, dir_n, pend_n, ack_n, abt_n, imask_n;
  logic [NUM_MBX-1:0] slot_mask, done_mask, cancel_mask, set_mask;
  logic [NUM_MBX-1:0] ack_clr, abt_clr;
  logic               upd_en;

  function automatic logic hit(input logic we, input logic [2:0] sel, input wr_sel_e code);
    return we && (sel == code);
  endfunction

  always_comb begin
    slot_mask   = slot_busy ? (ONE << slot_idx) : '0;
    done_mask   = slot_done ? slot_mask : '0;
    set_mask    = hit(wr_en, wr_sel, SEL_REQ_SET) ? wr_data : '0;
    cancel_mask = hit(wr_en, wr_sel, SEL_REQ_CLR) ? (wr_data & pend_q & ~slot_mask) : '0;
    ack_clr     = hit(wr_en, wr_sel, SEL_ACK_CLR) ? wr_data : '0;
    abt_clr     = hit(wr_en, wr_sel, SEL_ABT_CLR) ? wr_data : '0;

    en_n    = hit(wr_en, wr_sel, SEL_ENABLE) ? wr_data : en_q;
    dir_n   = hit(wr_en, wr_sel, SEL_DIR)    ? wr_data : dir_q;
    imask_n = hit(wr_en, wr_sel, SEL_IMASK)  ? wr_data : imask_q;
    pend_n  = ((pend_q & ~cancel_mask & ~done_mask) | set_mask) & en_n;
    ack_n   = (ack_q & ~ack_clr) | done_mask;
    abt_n   = (abt_q & ~abt_clr) | cancel_mask;
    upd_en  = wr_en | slot_done;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      en_q    <= '0;
      dir_q   <= '0;
      pend_q  <= '0;
      ack_q   <= '0;
      abt_q   <= '0;
      imask_q <= '0;
    end else if (upd_en) begin
      en_q    <= en_n;
      dir_q   <= dir_n;
      pend_q  <= pend_n;
      ack_q   <= ack_n;
      abt_q   <= abt_n;
      imask_q <= imask_n;
    end
  end
endmodule

// File: rtl/mbx_prio_store.sv
`timescale 1ns/1ps
module mbx_prio_store #(
  parameter int NUM_MBX = 32,
  parameter int PRIO_W  = 6,
  parameter int IDX_W   = 5
) (
  input  logic                      clk,
  input  logic                      arst_n,
  input  logic                      prio_wr,
  input  logic [IDX_W-1:0]          prio_idx,
  input  logic [PRIO_W-1:0]         prio_val,
  output logic [NUM_MBX*PRIO_W-1:0] prio_flat
);
  for (genvar g = 0; g < NUM_MBX; g++) begin : g_slot
    logic              sel;
    logic [PRIO_W-1:0] val_q;
    assign sel = prio_wr && (prio_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)  val_q <= '0;
      else if (sel) val_q <= prio_val;
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = val_q;
  end
endmodule

// File: rtl/mbx_prio_pick.sv
`timescale 1ns/1ps
module mbx_prio_pick #(
  parameter int NUM_MBX = 32,
  parameter int PRIO_W  = 6,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_MBX-1:0]        cand,
  input  logic [NUM_MBX*PRIO_W-1:0] prio_flat,
  output logic                      pick_valid,
  output logic [IDX_W-1:0]          pick_idx
);
  localparam int LEAVES = 1 << IDX_W;
  localparam int KEY_W  = 1 + PRIO_W + IDX_W;

  logic [KEY_W-1:0] leaf [LEAVES];
  logic [KEY_W-1:0] work [LEAVES];

  // Key = {candidate, priority, index}: the largest key is the winner,
  // and the index field breaks priority ties toward the higher mailbox.
  for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
    if (g < NUM_MBX) begin : g_real
      assign leaf[g] = cand[g] ? {1'b1, prio_flat[g*PRIO_W +: PRIO_W], IDX_W'(g)} : '0;
    end else begin : g_pad
      assign leaf[g] = '0;
    end
  end

  always_comb begin
    for (int i = 0; i < LEAVES; i++) work[i] = leaf[i];
    for (int w = LEAVES / 2; w >= 1; w = w / 2) begin
      for (int i = 0; i < w; i++) begin
        work[i] = (work[2*i] >= work[2*i+1]) ? work[2*i] : work[2*i+1];
      end
    end
    pick_valid = work[0][KEY_W-1];
    pick_idx   = work[0][IDX_W-1:0];
  end
endmodule

// File: rtl/mbx_slot_ctl.sv
`timescale 1ns/1ps
module mbx_slot_ctl #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             tx_start,
  input  logic             tx_done,
  input  logic             tx_abort,
  input  logic             pick_valid,
  input  logic [IDX_W-1:0] pick_idx,
  output logic             busy,
  output logic [IDX_W-1:0] lock_idx,
  output logic             slot_done,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx
);
  logic             busy_q, busy_n;
  logic [IDX_W-1:0] idx_q;
  logic             grab, release_slot;

  always_comb begin
    grab         = !busy_q && tx_start && pick_valid;
    release_slot = busy_q && (tx_done || tx_abort);
    slot_done    = busy_q && tx_done;
    busy_n       = busy_q;
    if (release_slot)  busy_n = 1'b0;
    else if (grab)     busy_n = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                    busy_q <= 1'b0;
    else if (grab || release_slot)  busy_q <= busy_n;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   idx_q <= '0;
    else if (grab) idx_q <= pick_idx;
  end

  assign busy      = busy_q;
  assign lock_idx  = idx_q;
  assign win_valid = busy_q | pick_valid;
  assign win_idx   = busy_q ? idx_q : pick_idx;
endmodule

// File: rtl/mbx_tx_arbiter.sv
`timescale 1ns/1ps
module mbx_tx_arbiter #(
  parameter int NUM_MBX = 32,
  parameter int PRIO_W  = 6,
  parameter int IDX_W   = $clog2(NUM_MBX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [NUM_MBX-1:0] wr_data,
  input  logic               prio_wr,
  input  logic [IDX_W-1:0]   prio_idx,
  input  logic [PRIO_W-1:0]  prio_val,
  input  logic               tx_start,
  input  logic               tx_done,
  input  logic               tx_abort,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output logic               busy,
  output logic               mbx_irq,
  output logic [NUM_MBX-1:0] mbx_en,
  output logic [NUM_MBX-1:0] mbx_dir,
  output logic [NUM_MBX-1:0] mbx_pend,
  output logic [NUM_MBX-1:0] mbx_ack,
  output logic [NUM_MBX-1:0] mbx_abt,
  output logic [NUM_MBX-1:0] mbx_imask
);
  logic [1:0]                rst_pipe_q;
  logic                      arst_n;
  logic [NUM_MBX*PRIO_W-1:0] prio_flat;
  logic [NUM_MBX-1:0]        cand;
  logic                      pick_valid, slot_done;
  logic [IDX_W-1:0]          pick_idx, lock_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign arst_n = rst_pipe_q[1];

  mbx_flag_bank #(.NUM_MBX(NUM_MBX), .IDX_W(IDX_W)) u_flags (
    .clk(clk), .arst_n(arst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .slot_busy(busy), .slot_idx(lock_idx), .slot_done(slot_done),
    .en_q(mbx_en), .dir_q(mbx_dir), .pend_q(mbx_pend),
    .ack_q(mbx_ack), .abt_q(mbx_abt), .imask_q(mbx_imask)
  );

  mbx_prio_store #(.NUM_MBX(NUM_MBX), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .arst_n(arst_n),
    .prio_wr(prio_wr), .prio_idx(prio_idx), .prio_val(prio_val),
    .prio_flat(prio_flat)
  );

  assign cand = mbx_en & ~mbx_dir & mbx_pend;

  mbx_prio_pick #(.NUM_MBX(NUM_MBX), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .cand(cand), .prio_flat(prio_flat),
    .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  mbx_slot_ctl #(.IDX_W(IDX_W)) u_slot (
    .clk(clk), .arst_n(arst_n),
    .tx_start(tx_start), .tx_done(tx_done), .tx_abort(tx_abort),
    .pick_valid(pick_valid), .pick_idx(pick_idx),
    .busy(busy), .lock_idx(lock_idx), .slot_done(slot_done),
    .win_valid(win_valid), .win_idx(win_idx)
  );

  assign mbx_irq = |((mbx_ack | mbx_abt) & mbx_imask);
endmodule

// File: rtl/mbx_tx_arbiter_chk.sv
`timescale 1ns/1ps
module mbx_tx_arbiter_chk #(
  parameter int NUM_MBX = 32,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               tx_done,
  input logic               tx_abort,
  input logic               win_valid,
  input logic [IDX_W-1:0]   win_idx,
  input logic               busy,
  input logic               mbx_irq,
  input logic [NUM_MBX-1:0] mbx_en,
  input logic [NUM_MBX-1:0] mbx_dir,
  input logic [NUM_MBX-1:0] mbx_pend,
  input logic [NUM_MBX-1:0] mbx_ack,
  input logic [NUM_MBX-1:0] mbx_abt
);
  logic [NUM_MBX-1:0] cand_c;
  assign cand_c = mbx_en & ~mbx_dir & mbx_pend;

  p_pend_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_pend & ~mbx_en) == '0);

  p_empty_no_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cand_c == '0) |-> !win_valid);

  p_winner_is_candidate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !busy) |-> cand_c[win_idx]);

  p_busy_has_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> win_valid);

  p_slot_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_done && !tx_abort) |=> (busy && $stable(win_idx)));

  p_done_sets_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_done) |=> (!busy && mbx_ack[$past(win_idx)]));

  p_abort_keeps_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_abort && !tx_done && !wr_en) |=>
      (!busy && mbx_pend[$past(win_idx)] == $past(mbx_pend[win_idx])));

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_ack == '0 && mbx_abt == '0) |-> !mbx_irq);
endmodule

bind mbx_tx_arbiter mbx_tx_arbiter_chk #(.NUM_MBX(NUM_MBX), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tx_done(tx_done), .tx_abort(tx_abort),
  .win_valid(win_valid), .win_idx(win_idx), .busy(busy), .mbx_irq(mbx_irq),
  .mbx_en(mbx_en), .mbx_dir(mbx_dir), .mbx_pend(mbx_pend),
  .mbx_ack(mbx_ack), .mbx_abt(mbx_abt)
);

// File: tb/mbx_tx_arbiter_tb_top.sv
`timescale 1ns/1ps
module mbx_tx_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        prio_wr = 1'b0;
  logic [4:0]  prio_idx = '0;
  logic [5:0]  prio_val = '0;
  logic        tx_start = 1'b0, tx_done = 1'b0, tx_abort = 1'b0;
  logic        win_valid, busy, mbx_irq;
  logic [4:0]  win_idx;
  logic [31:0] mbx_en, mbx_dir, mbx_pend, mbx_ack, mbx_abt, mbx_imask;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mbx_tx_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .prio_wr(prio_wr), .prio_idx(prio_idx), .prio_val(prio_val),
    .tx_start(tx_start), .tx_done(tx_done), .tx_abort(tx_abort),
    .win_valid(win_valid), .win_idx(win_idx), .busy(busy), .mbx_irq(mbx_irq),
    .mbx_en(mbx_en), .mbx_dir(mbx_dir), .mbx_pend(mbx_pend),
    .mbx_ack(mbx_ack), .mbx_abt(mbx_abt), .mbx_imask(mbx_imask)
  );

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] dir;
    logic [31:0] req;
    logic        vld;
    logic [4:0]  idx;
  } vec_t;

  // Priorities during the table: prio[i] = (i % 4) * 10, except prio[9] = 63.
  localparam vec_t VEC [9] = '{
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_00FF, 1'b1, 5'd7},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0280, 1'b1, 5'd9},
    '{32'hFFFF_FFFF, 32'h0000_0200, 32'h0000_0280, 1'b1, 5'd7},
    '{32'hFFFF_FF7F, 32'h0000_0000, 32'h0000_0088, 1'b1, 5'd3},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'd0},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h1111_1111, 1'b1, 5'd28},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001, 1'b1, 5'd31},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0, 5'd0},
    '{32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0006, 1'b1, 5'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_prio(input int idx, input int val);
    @(negedge clk);
    prio_wr = 1'b1; prio_idx = 5'(idx); prio_val = 6'(val);
    @(negedge clk);
    prio_wr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
  endtask
  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
  endtask
  task automatic pulse_abort();
    @(negedge clk); tx_abort = 1'b1; @(negedge clk); tx_abort = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired before all requirement checks ran");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 enable", mbx_en, 0);
    chk("R1 pending", mbx_pend, 0);
    chk("R1 acks", mbx_ack | mbx_abt, 0);
    chk("R1 mask/dir", mbx_imask | mbx_dir, 0);
    chk("R1 valid/busy/irq", {29'd0, win_valid, busy, mbx_irq}, 0);

    for (int i = 0; i < 32; i++) set_prio(i, (i % 4) * 10);
    set_prio(9, 63);

    // R3 R5 table walk
    for (int v = 0; v < 9; v++) begin
      wr(3'd0, 32'h0);
      wr(3'd1, VEC[v].dir);
      wr(3'd0, VEC[v].en);
      wr(3'd2, VEC[v].req);
      chk($sformatf("R3 pending vec %0d", v), mbx_pend, VEC[v].req & VEC[v].en);
      chk($sformatf("R5 valid vec %0d", v), {31'd0, win_valid}, {31'd0, VEC[v].vld});
      if (VEC[v].vld)
        chk($sformatf("R5 index vec %0d", v), {27'd0, win_idx}, {27'd0, VEC[v].idx});
    end

    // R2 readback
    wr(3'd1, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    chk("R2 direction", mbx_dir, 0);
    chk("R2 enable", mbx_en, 32'hFFFF_FFFF);

    // R6 tie at 63, then priority change
    set_prio(0, 63);
    wr(3'd2, 32'h0000_0201);
    chk("R6 tie high index", {27'd0, win_idx}, 9);
    set_prio(9, 1);
    chk("R6 new priority wins", {27'd0, win_idx}, 0);
    set_prio(9, 63);
    set_prio(0, 0);
    wr(3'd0, 32'h0);
    chk("R4 disable drops pending", mbx_pend, 0);
    wr(3'd0, 32'hFFFF_FFFF);

    // R7 latch and hold
    wr(3'd2, 32'h0000_0004);
    chk("R5 single candidate", {27'd0, win_idx}, 2);
    pulse_start();
    chk("R7 busy", {31'd0, busy}, 1);
    wr(3'd2, 32'h0000_0200);
    chk("R7 held index", {27'd0, win_idx}, 2);
    chk("R7 valid while busy", {31'd0, win_valid}, 1);
    wr(3'd3, 32'h0000_0004);
    chk("R9 latched not cancelled", mbx_pend, 32'h0000_0204);
    chk("R9 no abort ack", mbx_abt, 0);

    // R8 done then abort
    pulse_done();
    chk("R8 done ack", mbx_ack, 32'h0000_0004);
    chk("R8 done pending", mbx_pend, 32'h0000_0200);
    chk("R8 released", {31'd0, busy}, 0);
    chk("R8 next winner", {27'd0, win_idx}, 9);
    pulse_start();
    chk("R7 second latch", {31'd0, busy}, 1);
    pulse_abort();
    chk("R8 abort released", {31'd0, busy}, 0);
    chk("R8 abort keeps pending", mbx_pend, 32'h0000_0200);

    // R9 cancel
    wr(3'd3, 32'h0000_0200);
    chk("R9 cancel pending", mbx_pend, 0);
    chk("R9 abort ack", mbx_abt, 32'h0000_0200);
    chk("R5 no candidate", {31'd0, win_valid}, 0);
    wr(3'd3, 32'h0000_0201);
    chk("R9 cancel idle no effect", mbx_abt, 32'h0000_0200);

    // R10 R11 interrupt and clears
    chk("R11 masked off", {31'd0, mbx_irq}, 0);
    wr(3'd6, 32'h0000_0200);
    chk("R2 mask readback", mbx_imask, 32'h0000_0200);
    chk("R11 abort ack irq", {31'd0, mbx_irq}, 1);
    wr(3'd5, 32'h0000_0200);
    chk("R10 abort ack clear", mbx_abt, 0);
    chk("R11 irq drops", {31'd0, mbx_irq}, 0);
    wr(3'd6, 32'h0000_0004);
    chk("R11 tx ack irq", {31'd0, mbx_irq}, 1);
    wr(3'd4, 32'h0000_0004);
    chk("R10 tx ack clear", mbx_ack, 0);
    chk("R11 irq drops again", {31'd0, mbx_irq}, 0);

    // R12 stray strobes
    pulse_start();
    chk("R12 start without candidate", {31'd0, busy}, 0);
    pulse_done();
    pulse_abort();
    chk("R12 done while idle", mbx_ack, 0);
    chk("R12 pending untouched", mbx_pend, 0);

    // R3 disabled mailbox, R4 enable clear
    wr(3'd0, 32'hFFFF_FFEF);
    wr(3'd2, 32'h0000_0030);
    chk("R3 disabled not pended", mbx_pend, 32'h0000_0020);
    wr(3'd0, 32'hFFFF_FFCF);
    chk("R4 enable clear drops", mbx_pend, 0);
    chk("R4 no winner", {31'd0, win_valid}, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule